// File: doc/BRIEF.md
# DSP Memory Loader with Staged Coefficient Updates

This block sits between a byte-wide host port and the three internal memories of an audio signal processor: a program memory with 32-bit words, and a coefficient memory and an offset memory with 16-bit words each. The host sends command bytes and data bytes on the same lane. A separate select line marks which bytes are commands. One command loads a 16-bit write pointer. Other commands choose which memory takes the data words that follow. Every accepted word advances the pointer by one.

Coefficient and offset words can be written straight through, or collected in a 32-word staging buffer. A mode input picks between the two. A staged batch is written to its memory in one burst, one word per clock. The burst starts on the first sample strobe after the host marks the end of the batch, so the filter never runs on a mix of old and new coefficients. A staged batch must cover one unbroken ascending address run that fits in the buffer and in the target memory. Any other batch is discarded and a sticky error flag is raised.

Top module: `dsp_ram_loader`

## Requirements
- R1: After reset all three write enables are low and the error flag is low.
- R2: Command byte 0x0C followed by two data bytes, most significant byte first, sets the write pointer. If no staged batch is open, this command also disarms any selected memory.
- R3: Each accepted data word goes to the current pointer, and the pointer then advances by one. This holds for direct, staged and program words.
- R4: Command 0x0A selects program memory. Each following group of four data bytes, most significant first, is one 32-bit word. It is written with progWe high one cycle after its last byte, in both modes.
- R5: Command 0x09 selects coefficient memory and 0x08 selects offset memory. Each following pair of data bytes is one word. The word appears on wrData[15:0] with the upper bits zero, and at most one write enable is high in any cycle.
- R6: With bufModeEn low when the select command arrives, each coefficient or offset word is written one cycle after its last byte.
- R7: With bufModeEn high when the select command arrives, coefficient and offset words cause no write on arrival. They are held for a later commit.
- R8: With bufModeEn high, a 16-bit word received while no memory is selected is held. The next 0x09 or 0x08 command places it as the first word of the batch, at the current pointer.
- R9: A batchEnd pulse on an open staged batch arms a commit. The commit starts on the first sampleStb in a later cycle; a strobe in the same cycle as batchEnd does not start it. The commit writes the batch in ascending address order from its first address, one word per cycle, with the first write one cycle after the strobe.
- R10: A staged word beyond 32 in a batch, or any word whose pointer is at or past the end of its memory, sets the error flag. That word is not written, any open batch is discarded and the memory is disarmed.
- R11: If 0x0C arrives during an open staged batch and the new address differs from the pointer, the error flag is set and the batch is discarded. An equal address lets the batch continue.
- R12: A data word that completes while a commit is armed or running is dropped, and it sets the error flag.
- R13: The error flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostStb | input | 1 | One host byte is present this cycle |
| hostIsCmd | input | 1 | High: hostByte is a command; low: data |
| hostByte | input | 8 | Host byte |
| bufModeEn | input | 1 | 1 selects staged updates, 0 selects direct writes |
| batchEnd | input | 1 | Host marks the open staged batch as complete |
| sampleStb | input | 1 | Sample-period boundary pulse |
| progWe | output | 1 | Program memory write enable |
| coefWe | output | 1 | Coefficient memory write enable |
| offWe | output | 1 | Offset memory write enable |
| wrAddr | output | 16 | Write address for the enabled memory |
| wrData | output | 32 | Write data; 16-bit memories use the low half |
| errFlag | output | 1 | Sticky batch or address error |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the end-of-batch mark and the sample strobe. The bench pulses both in one cycle and expects no write until a later strobe. The second pair is a host word finishing while a commit is armed or while its burst is running. The bench finishes one word between batchEnd and the strobe, and another in the middle of the burst. It expects both words to be dropped, the error flag to rise, and the burst to keep its exact addresses and cycles. A behavioural model predicts every write and its cycle, and this is compared with the ports on every clock.

// File: rtl/dsp_load_pkg.sv
`timescale 1ns/1ps
package dsp_load_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 16;
  localparam int PROG_W     = 32;
  localparam int DATA_W     = 16;
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int PROG_BYTES = PROG_W / BYTE_W;
  localparam int DATA_BYTES = DATA_W / BYTE_W;
  localparam int BCNT_W     = $clog2(PROG_BYTES);

  localparam logic [BYTE_W-1:0] CMD_ADDR = 8'h0C;
  localparam logic [BYTE_W-1:0] CMD_PROG = 8'h0A;
  localparam logic [BYTE_W-1:0] CMD_COEF = 8'h09;
  localparam logic [BYTE_W-1:0] CMD_OFF  = 8'h08;

  typedef enum logic [1:0] {TGT_NONE, TGT_PROG, TGT_COEF, TGT_OFF} tgt_e;

  typedef struct packed {
    logic shiftIn;
    logic ldPtr;
    logic incPtr;
    logic holdLoad;
    logic holdToBuf;
    logic latchStart;
    logic bufWr;
    logic commitWr;
    logic directWr;
    tgt_e wrSel;
  } strobe_t;
endpackage

// File: rtl/dsp_load_ctrl.sv
`timescale 1ns/1ps
module dsp_load_ctrl
  import dsp_load_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  localparam int IDX_W = $clog2(BUF_DEPTH),
  localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStb,
  input  logic              hostIsCmd,
  input  logic [BYTE_W-1:0] hostByte,
  input  logic              bufModeEn,
  input  logic              batchEnd,
  input  logic              sampleStb,
  input  logic              addrMismatch,
  input  logic              pastProg,
  input  logic              pastCoef,
  input  logic              pastOff,
  output strobe_t           strb,
  output logic [IDX_W-1:0]  bufIdx,
  output logic              errFlag
);
  tgt_e              tgt, commitTgt;
  logic              addrPhase, buffered, holdValid, pending, committing;
  logic [BCNT_W-1:0] byteCnt, needLast;
  logic [CNT_W-1:0]  count;
  logic [IDX_W-1:0]  idx;
  logic              busy, openBatch, wordDone, selCmd, pastTgt, pastSel;
  tgt_e              selTgt;

  assign busy      = pending | committing;
  assign openBatch = buffered && (tgt == TGT_COEF || tgt == TGT_OFF) && count != '0 && !busy;
  assign needLast  = addrPhase ? BCNT_W'(ADDR_BYTES - 1)
                   : (tgt == TGT_PROG) ? BCNT_W'(PROG_BYTES - 1) : BCNT_W'(DATA_BYTES - 1);
  assign wordDone  = hostStb && !hostIsCmd && byteCnt == needLast;
  assign selCmd    = hostStb && hostIsCmd && (hostByte == CMD_COEF || hostByte == CMD_OFF);
  assign selTgt    = (hostByte == CMD_COEF) ? TGT_COEF : TGT_OFF;
  assign pastTgt   = (tgt == TGT_COEF) ? pastCoef : (tgt == TGT_OFF) ? pastOff : pastProg;
  assign pastSel   = (selTgt == TGT_COEF) ? pastCoef : pastOff;
  assign bufIdx    = committing ? idx : count[IDX_W-1:0];

  always_comb begin
    strb = '0;
    strb.wrSel = TGT_NONE;
    strb.shiftIn = hostStb && !hostIsCmd;
    if (committing) begin
      strb.commitWr = 1'b1;
      strb.wrSel = commitTgt;
    end
    if (wordDone) begin
      if (addrPhase) strb.ldPtr = 1'b1;
      else begin
        case (tgt)
          TGT_NONE: strb.holdLoad = bufModeEn;
          TGT_PROG: if (!busy && !pastProg) begin
            strb.directWr = 1'b1; strb.wrSel = TGT_PROG; strb.incPtr = 1'b1;
          end
          default: if (!busy && !pastTgt) begin
            if (!buffered) begin
              strb.directWr = 1'b1; strb.wrSel = tgt; strb.incPtr = 1'b1;
            end else if (count != CNT_W'(BUF_DEPTH)) begin
              strb.bufWr = 1'b1; strb.incPtr = 1'b1; strb.latchStart = (count == '0);
            end
          end
        endcase
      end
    end
    if (selCmd && !busy && bufModeEn && holdValid && !pastSel) begin
      strb.holdToBuf = 1'b1; strb.latchStart = 1'b1; strb.incPtr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgt <= TGT_NONE; commitTgt <= TGT_NONE;
      addrPhase <= 1'b0; buffered <= 1'b0; holdValid <= 1'b0;
      pending <= 1'b0; committing <= 1'b0; errFlag <= 1'b0;
      byteCnt <= '0; count <= '0; idx <= '0;
    end else begin
      if (hostStb && hostIsCmd) begin
        byteCnt <= '0;
        if (hostByte == CMD_ADDR) addrPhase <= 1'b1;
        else if (hostByte == CMD_PROG && !busy) begin
          tgt <= TGT_PROG; addrPhase <= 1'b0; holdValid <= 1'b0; count <= '0;
        end else if (selCmd && !busy) begin
          tgt <= selTgt; buffered <= bufModeEn; addrPhase <= 1'b0;
          holdValid <= 1'b0; count <= '0;
          if (bufModeEn && holdValid) begin
            if (pastSel) begin errFlag <= 1'b1; tgt <= TGT_NONE; end
            else count <= CNT_W'(1);
          end
        end
      end else if (wordDone) begin
        byteCnt <= '0;
        if (addrPhase) begin
          addrPhase <= 1'b0;
          if (!openBatch) tgt <= TGT_NONE;
          else if (addrMismatch) begin
            errFlag <= 1'b1; tgt <= TGT_NONE; count <= '0;
          end
        end else begin
          case (tgt)
            TGT_NONE: if (bufModeEn) holdValid <= 1'b1;
            TGT_PROG: if (busy) errFlag <= 1'b1;
                      else if (pastProg) begin errFlag <= 1'b1; tgt <= TGT_NONE; end
            default: begin
              if (busy) errFlag <= 1'b1;
              else if (pastTgt || (buffered && count == CNT_W'(BUF_DEPTH))) begin
                errFlag <= 1'b1; tgt <= TGT_NONE; count <= '0;
              end else if (buffered) count <= count + 1'b1;
            end
          endcase
        end
      end else if (hostStb) byteCnt <= byteCnt + 1'b1;

      if (batchEnd && openBatch) begin
        pending <= 1'b1; commitTgt <= tgt;
      end
      if (committing) begin
        idx <= idx + 1'b1;
        if (CNT_W'(idx) + 1'b1 == count) begin
          committing <= 1'b0; count <= '0; idx <= '0;
        end
      end else if (pending && sampleStb) begin
        committing <= 1'b1; pending <= 1'b0; idx <= '0;
      end
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(BUF_DEPTH));
  p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  p_pend_waits_r9: assert property (@(posedge clk) disable iff (!rstN)
    pending && !sampleStb |=> pending);
  p_commit_on_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(committing) |-> $past(sampleStb));
endmodule

// File: rtl/dsp_load_path.sv
`timescale 1ns/1ps
module dsp_load_path
  import dsp_load_pkg::*;
#(
  parameter int BUF_DEPTH  = 32,
  parameter int PROG_DEPTH = 256,
  parameter int COEF_DEPTH = 64,
  parameter int OFF_DEPTH  = 64,
  localparam int IDX_W = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] hostByte,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  bufIdx,
  output logic              addrMismatch,
  output logic              pastProg,
  output logic              pastCoef,
  output logic              pastOff,
  output logic              progWe,
  output logic              coefWe,
  output logic              offWe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [PROG_W-1:0] wrData
);
  logic [PROG_W-BYTE_W-1:0] shiftReg;
  logic [PROG_W-1:0]        wordNow;
  logic [ADDR_W-1:0]        ptr, startAddr;
  logic [DATA_W-1:0]        hold;
  logic [DATA_W-1:0]        bufMem [BUF_DEPTH];

  assign wordNow      = {shiftReg, hostByte};
  assign addrMismatch = wordNow[ADDR_W-1:0] != ptr;
  assign pastProg     = 32'(ptr) >= PROG_DEPTH;
  assign pastCoef     = 32'(ptr) >= COEF_DEPTH;
  assign pastOff      = 32'(ptr) >= OFF_DEPTH;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0; ptr <= '0; startAddr <= '0; hold <= '0;
      progWe <= 1'b0; coefWe <= 1'b0; offWe <= 1'b0;
      wrAddr <= '0; wrData <= '0;
    end else begin
      if (strb.shiftIn) shiftReg <= wordNow[PROG_W-BYTE_W-1:0];
      if (strb.ldPtr) ptr <= wordNow[ADDR_W-1:0];
      else if (strb.incPtr) ptr <= ptr + 1'b1;
      if (strb.latchStart) startAddr <= ptr;
      if (strb.holdLoad) hold <= wordNow[DATA_W-1:0];
      progWe <= 1'b0; coefWe <= 1'b0; offWe <= 1'b0;
      if (strb.commitWr || strb.directWr) begin
        progWe <= strb.wrSel == TGT_PROG;
        coefWe <= strb.wrSel == TGT_COEF;
        offWe  <= strb.wrSel == TGT_OFF;
      end
      if (strb.commitWr) begin
        wrAddr <= startAddr + ADDR_W'(bufIdx);
        wrData <= PROG_W'(bufMem[bufIdx]);
      end else if (strb.directWr) begin
        wrAddr <= ptr;
        wrData <= (strb.wrSel == TGT_PROG) ? wordNow : PROG_W'(wordNow[DATA_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.holdToBuf) bufMem[0] <= hold;
    else if (strb.bufWr) bufMem[bufIdx] <= wordNow[DATA_W-1:0];
  end

  p_onehot_we_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progWe, coefWe, offWe}));
  p_commit_ascending_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitWr && $past(strb.commitWr) |=> wrAddr == $past(wrAddr) + ADDR_W'(1));
endmodule

// File: rtl/dsp_ram_loader.sv
`timescale 1ns/1ps
module dsp_ram_loader
  import dsp_load_pkg::*;
#(
  parameter int BUF_DEPTH  = 32,
  parameter int PROG_DEPTH = 256,
  parameter int COEF_DEPTH = 64,
  parameter int OFF_DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStb,
  input  logic              hostIsCmd,
  input  logic [BYTE_W-1:0] hostByte,
  input  logic              bufModeEn,
  input  logic              batchEnd,
  input  logic              sampleStb,
  output logic              progWe,
  output logic              coefWe,
  output logic              offWe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [PROG_W-1:0] wrData,
  output logic              errFlag
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  strobe_t          strb;
  logic [IDX_W-1:0] bufIdx;
  logic             addrMismatch, pastProg, pastCoef, pastOff;

  dsp_load_ctrl #(.BUF_DEPTH(BUF_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostStb(hostStb), .hostIsCmd(hostIsCmd),
    .hostByte(hostByte), .bufModeEn(bufModeEn), .batchEnd(batchEnd),
    .sampleStb(sampleStb), .addrMismatch(addrMismatch), .pastProg(pastProg),
    .pastCoef(pastCoef), .pastOff(pastOff), .strb(strb), .bufIdx(bufIdx),
    .errFlag(errFlag));

  dsp_load_path #(.BUF_DEPTH(BUF_DEPTH), .PROG_DEPTH(PROG_DEPTH),
                  .COEF_DEPTH(COEF_DEPTH), .OFF_DEPTH(OFF_DEPTH)) u_path (
    .clk(clk), .rstN(rstN), .hostByte(hostByte), .strb(strb), .bufIdx(bufIdx),
    .addrMismatch(addrMismatch), .pastProg(pastProg), .pastCoef(pastCoef),
    .pastOff(pastOff), .progWe(progWe), .coefWe(coefWe), .offWe(offWe),
    .wrAddr(wrAddr), .wrData(wrData));
endmodule

// File: tb/dsp_ram_loader_tb.sv
`timescale 1ns/1ps
module dsp_ram_loader_tb;
  localparam int PROG_DEPTH = 256;
  localparam int COEF_DEPTH = 64;
  localparam int OFF_DEPTH  = 64;
  localparam int BUF_DEPTH  = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostStb = 1'b0, hostIsCmd = 1'b0, bufModeEn = 1'b0, batchEnd = 1'b0, sampleStb = 1'b0;
  logic [7:0] hostByte = '0;
  logic progWe, coefWe, offWe, errFlag;
  logic [15:0] wrAddr;
  logic [31:0] wrData;

  dsp_ram_loader u_dut (.clk(clk), .rstN(rstN), .hostStb(hostStb), .hostIsCmd(hostIsCmd),
    .hostByte(hostByte), .bufModeEn(bufModeEn), .batchEnd(batchEnd), .sampleStb(sampleStb),
    .progWe(progWe), .coefWe(coefWe), .offWe(offWe), .wrAddr(wrAddr), .wrData(wrData),
    .errFlag(errFlag));

  always #2.5 clk = ~clk;

  typedef struct {int sel; int addr; int data; int cyc;} exp_t;
  exp_t expQ[$];
  int mBuf[$];
  int cyc = 0, checks = 0, errors = 0;
  int mPtr, mTgt, mBuffered, mHoldV, mHold, mStart, mPend, mCommitTgt, mErr;
  int commitFirst, commitLast;
  bit monOn = 1'b0, done = 1'b0;
  string curReq = "R1";

  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic bit isBusy(int e);
    return mPend != 0 || (e >= commitFirst && e <= commitLast);
  endfunction
  function automatic bit isOpen(int e);
    return mBuffered != 0 && mTgt >= 2 && mBuf.size() > 0 && !isBusy(e);
  endfunction
  function automatic int depthOf(int t);
    return t == 1 ? PROG_DEPTH : t == 2 ? COEF_DEPTH : OFF_DEPTH;
  endfunction

  always @(negedge clk) begin
    if (monOn && rstN) begin
      int sel;
      sel = progWe ? 1 : coefWe ? 2 : offWe ? 3 : 0;
      chk(errFlag == mErr[0], curReq, "errFlag", errFlag, mErr);
      while (expQ.size() > 0 && expQ[0].cyc < cyc) begin
        chk(0, curReq, "missing write addr", -1, expQ[0].addr);
        void'(expQ.pop_front());
      end
      if (sel != 0) begin
        if (expQ.size() == 0) chk(0, curReq, "unexpected write addr", wrAddr, -1);
        else begin
          exp_t x;
          x = expQ.pop_front();
          chk(sel == x.sel, curReq, "write target", sel, x.sel);
          chk(int'(wrAddr) == x.addr, curReq, "write addr", wrAddr, x.addr);
          chk(int'(wrData) == x.data, curReq, "write data", wrData, x.data);
          chk(cyc == x.cyc, curReq, "write cycle", cyc, x.cyc);
        end
      end
    end
  end

  task automatic putByte(bit cmd, int b, output int e);
    @(negedge clk);
    hostStb = 1'b1; hostIsCmd = cmd; hostByte = 8'(b); e = cyc + 1;
    @(posedge clk); #1;
    hostStb = 1'b0;
  endtask

  task automatic doReset();
    monOn = 1'b0;
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mPtr = 0; mTgt = 0; mBuffered = 0; mHoldV = 0; mHold = 0; mStart = 0;
    mPend = 0; mCommitTgt = 0; mErr = 0; commitFirst = 0; commitLast = -1;
    mBuf.delete(); expQ.delete();
    #1;
    chk({progWe, coefWe, offWe} == 3'b000, "R1", "write enables after reset",
        {progWe, coefWe, offWe}, 0);
    chk(errFlag == 1'b0, "R1", "errFlag after reset", errFlag, 0);
    monOn = 1'b1;
  endtask

  task automatic setAddr(int a);
    int e;
    putByte(1, 8'h0C, e); putByte(0, a >> 8, e); putByte(0, a & 255, e);
    if (isOpen(e)) begin
      if (a != mPtr) begin mErr = 1; mTgt = 0; mBuf.delete(); end
    end else mTgt = 0;
    mPtr = a;
  endtask

  task automatic selTgt(int code);
    int e;
    putByte(1, code, e);
    if (isBusy(e)) return;
    mTgt = code == 8'h0A ? 1 : code == 8'h09 ? 2 : 3;
    mBuf.delete();
    if (mTgt >= 2) begin
      mBuffered = bufModeEn;
      if (bufModeEn && mHoldV != 0) begin
        if (mPtr >= depthOf(mTgt)) begin mErr = 1; mTgt = 0; end
        else begin mStart = mPtr; mBuf.push_back(mHold); mPtr++; end
      end
    end
    mHoldV = 0;
  endtask

  task automatic sendWord(int w);
    int e, n;
    n = (mTgt == 1) ? 4 : 2;
    for (int i = n - 1; i >= 0; i--) putByte(0, (w >> (8 * i)) & 255, e);
    if (mTgt == 0) begin
      if (bufModeEn) begin mHold = w & 16'hFFFF; mHoldV = 1; end
    end else if (isBusy(e)) mErr = 1;
    else if (mPtr >= depthOf(mTgt)) begin mErr = 1; mTgt = 0; mBuf.delete(); end
    else if (mTgt == 1 || mBuffered == 0) begin
      expQ.push_back('{mTgt, mPtr, (mTgt == 1) ? w : (w & 16'hFFFF), e});
      mPtr++;
    end else if (mBuf.size() == BUF_DEPTH) begin mErr = 1; mTgt = 0; mBuf.delete(); end
    else begin
      if (mBuf.size() == 0) mStart = mPtr;
      mBuf.push_back(w & 16'hFFFF); mPtr++;
    end
  endtask

  task automatic pulse(bit doEnd, bit doSample);
    int e;
    @(negedge clk);
    batchEnd = doEnd; sampleStb = doSample; e = cyc + 1;
    @(posedge clk); #1;
    batchEnd = 1'b0; sampleStb = 1'b0;
    if (doSample && mPend != 0) begin
      for (int i = 0; i < mBuf.size(); i++)
        expQ.push_back('{mCommitTgt, mStart + i, mBuf[i], e + 1 + i});
      commitFirst = e + 1; commitLast = e + mBuf.size();
      mPend = 0; mBuf.delete();
    end
    if (doEnd && isOpen(e)) begin mPend = 1; mCommitTgt = mTgt; end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    curReq = "R2"; // R2 R3 R4: program words at a loaded address
    setAddr(16'h00F0); selTgt(8'h0A);
    sendWord(32'h1234_5678); sendWord(32'hCAFE_F00D);
    curReq = "R4"; sendWord(32'h8000_0001); idle(3);

    curReq = "R6"; // R5 R6: direct coefficient and offset writes
    bufModeEn = 1'b0; setAddr(5); selTgt(8'h09); sendWord(16'hA1B2); sendWord(16'h0003);
    curReq = "R5"; selTgt(8'h08); sendWord(16'hFFEE); idle(3);

    curReq = "R7"; // R7: staged words stay silent, program stays direct
    bufModeEn = 1'b1; selTgt(8'h0A); sendWord(32'h0BAD_BEEF);
    setAddr(20); selTgt(8'h09); sendWord(16'h1111); sendWord(16'h2222); sendWord(16'h3333);
    idle(4);
    curReq = "R9"; // same cycle end and strobe, then a later strobe
    pulse(1, 1); idle(3); pulse(0, 1); idle(6);

    curReq = "R8"; // held word becomes first entry
    setAddr(40); sendWord(16'hAAAA); selTgt(8'h08); sendWord(16'h5555); sendWord(16'h7777);
    pulse(1, 0); pulse(0, 1); idle(6);

    curReq = "R11"; // equal address continues the batch
    setAddr(50); selTgt(8'h09); sendWord(16'h0050); sendWord(16'h0051);
    setAddr(52); sendWord(16'h0052); pulse(1, 0); idle(2); pulse(0, 1); idle(6);
    chk(errFlag == 1'b0, "R11", "errFlag after equal address", errFlag, 0);

    curReq = "R12"; // words while armed and while bursting are dropped
    setAddr(8); selTgt(8'h09); sendWord(16'h0808); sendWord(16'h0909); sendWord(16'h0A0A);
    pulse(1, 0); sendWord(16'hDEAD);
    chk(errFlag == 1'b1, "R12", "errFlag after word while armed", errFlag, 1);
    pulse(0, 1); sendWord(16'hBEEF); idle(6);
    curReq = "R13"; // error stays while valid traffic continues
    bufModeEn = 1'b0; setAddr(2); selTgt(8'h08); sendWord(16'h4242); idle(4);
    chk(errFlag == 1'b1, "R13", "errFlag sticky", errFlag, 1);

    doReset();
    curReq = "R11"; // differing address discards the batch
    bufModeEn = 1'b1; setAddr(10); selTgt(8'h09); sendWord(16'h0010); sendWord(16'h0011);
    setAddr(30); pulse(1, 0); pulse(0, 1); idle(6);
    chk(errFlag == 1'b1, "R11", "errFlag after address jump", errFlag, 1);

    doReset();
    curReq = "R10"; // 33rd staged word
    bufModeEn = 1'b1; setAddr(0); selTgt(8'h09);
    for (int i = 0; i < BUF_DEPTH + 1; i++) sendWord(16'h0100 + i);
    pulse(1, 0); pulse(0, 1); idle(40);
    chk(errFlag == 1'b1, "R10", "errFlag after overflow", errFlag, 1);

    doReset();
    curReq = "R10"; // pointer at the end of the memory
    bufModeEn = 1'b0; setAddr(COEF_DEPTH - 1); selTgt(8'h09);
    sendWord(16'h6363); sendWord(16'h6464); sendWord(16'h6565); idle(4);
    chk(errFlag == 1'b1, "R10", "errFlag past end", errFlag, 1);
    chk(expQ.size() == 0, "R3", "pending expected writes", expQ.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule